// File: doc/BRIEF.md
# Presettable Up/Down Decade or Binary Counter Digit

This block is one digit of a synchronous up/down counter. A parameter picks its radix: decade, which runs through 0 to 9, or binary, which runs through the full 0 to 15 range of a 4-bit field. On each rising clock edge the digit steps once when its active-low count enable is low. A direction input selects whether it counts up or down.

Two level-sensitive controls override counting. The clear input forces the count to zero. The load input forces the count to the value on the jam inputs. Both show at the count output in the same cycle they are raised, with no clock edge needed, and the stored state follows them at the next edge. Clear wins over load.

An active-low carry-out is built combinationally from the count-enable input and the digit's terminal value. This lets digits that share one clock form a wide synchronous counter: each digit's carry-out drives the count enable of the next more significant digit. In decade mode a jammed code from 10 to 15 is illegal, and it is left on the next counting edge.

Top module: `ud_digit_counter`

## Requirements
- R1: While `clr` is 1, `count` reads 0 at once and the stored count is 0 after the next rising edge, whatever `load`, `ci_n`, `up` and `jam` hold.
- R2: While `clr` is 0 and `load` is 1, `count` equals `jam` at once and after every rising edge; no counting takes place.
- R3: When `clr` and `load` are both 1, `count` is 0.
- R4: With `clr`=0, `load`=0, `ci_n`=0 and `up`=1, each rising edge adds one to the count. The top value wraps to 0. The top value is 9 in decade mode and 15 in binary mode.
- R5: With `clr`=0, `load`=0, `ci_n`=0 and `up`=0, each rising edge subtracts one from the count. A count of 0 wraps to the top value: 9 in decade mode, 15 in binary mode.
- R6: With `ci_n`=1, and `clr` and `load` both 0, the count keeps its value across rising edges.
- R7: `co_n` is 0 exactly when `ci_n` is 0 and the count equals the terminal value for the current direction. That value is the top value when `up`=1 and 0 when `up`=0. `co_n` follows `ci_n` with no clock edge in between.
- R8: In decade mode, a count of 10 to 15 goes to 0 on the next counting edge when `up`=1 and to 9 when `up`=0. This lies within the bound of two edges up and four edges down. `co_n` stays 1 while such a code is held.
- R9: In decade mode, a jam value of 10 to 15 is loaded unchanged.
- R10: Three decade digits that share a clock, chained carry-out to count enable, count 000 to 999 and wrap to 000 going up. Going down they count from 000 to 999 and on down to 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Level clear to zero, active high, highest priority |
| load | input | 1 | Level parallel load of `jam`, active high |
| ci_n | input | 1 | Count enable / carry in, active low |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| jam | input | W | Parallel load value |
| count | output | W | Current count |
| co_n | output | 1 | Carry out to the next digit, active low |

## Verification
Results arrive at three different times. The clear and load overrides and the carry-out are combinational: they are checked one nanosecond after their inputs change, with no clock edge in between. A counting step is due at the first rising edge after the inputs are set, so the bench drives inputs at a falling edge, waits for one rising edge and samples at the next falling edge. Recovery from an illegal code is checked after exactly one counting edge. The carry-out check ties a ripple across three digits to that same single edge.

// File: rtl/ud_cnt_pkg.sv
// Package: shared radix selector and top-value helper for the counter digit.
// Assumes: WIDTH is at least 4 whenever the decade radix is chosen.
package ud_cnt_pkg;

    typedef enum logic {
        RADIX_BINARY = 1'b0,
        RADIX_DECADE = 1'b1
    } radix_e;

    // Largest legal count for a given radix and field width.
    function automatic int unsigned top_value(radix_e radix, int unsigned width);
        return (radix == RADIX_DECADE) ? 9 : ((1 << width) - 1);
    endfunction

endpackage

// File: rtl/ud_step.sv
// Module: ud_step
// Computes the count the digit would take on a counting edge, given the
// present count and direction. In decade mode codes above the top value
// are steered straight back into range.
// Assumes: cur is the stored count; no clocked state here.
module ud_step #(
    parameter int unsigned        W     = 4,
    parameter ud_cnt_pkg::radix_e RADIX = ud_cnt_pkg::RADIX_DECADE
) (
    input  logic [W-1:0] cur,
    input  logic         up,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] TOP = W'(ud_cnt_pkg::top_value(RADIX, W));

    generate
        if (RADIX == ud_cnt_pkg::RADIX_DECADE) begin : g_decade
            // Decade step: wrap at 9/0 and pull illegal codes to 0 or 9.
            always_comb begin
                if (up) begin
                    nxt = (cur >= TOP) ? '0 : cur + 1'b1;
                end else if (cur > TOP) begin
                    nxt = TOP;
                end else if (cur == '0) begin
                    nxt = TOP;
                end else begin
                    nxt = cur - 1'b1;
                end
            end
        end else begin : g_binary
            // Binary step: plain modulo-2^W increment or decrement.
            always_comb begin
                nxt = up ? cur + 1'b1 : cur - 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/ud_carry.sv
// Module: ud_carry
// Active-low carry out: low only while the digit is enabled and sits at
// the terminal value of the present direction. Purely combinational so a
// carry ripples through a chain within one clock period.
// Assumes: cur is the visible count (overrides already applied).
module ud_carry #(
    parameter int unsigned        W     = 4,
    parameter ud_cnt_pkg::radix_e RADIX = ud_cnt_pkg::RADIX_DECADE
) (
    input  logic [W-1:0] cur,
    input  logic         up,
    input  logic         ci_n,
    output logic         co_n
);
    localparam logic [W-1:0] TOP = W'(ud_cnt_pkg::top_value(RADIX, W));

    logic at_end;

    // Terminal detect for the selected direction; illegal codes never match.
    always_comb begin
        at_end = up ? (cur == TOP) : (cur == '0);
        co_n   = ~(~ci_n & at_end);
    end
endmodule

// File: rtl/ud_digit_counter.sv
// Module: ud_digit_counter
// One presettable up/down digit. The clear and load controls are level
// sensitive: they override the visible count at once and are captured
// into the stored count on the next rising edge. Counting is enabled by
// an active-low carry in; the carry out feeds the next digit's carry in.
// Assumes: clear or load is held across at least one rising edge when
// the stored value must keep it after release.
module ud_digit_counter #(
    parameter int unsigned        W     = 4,
    parameter ud_cnt_pkg::radix_e RADIX = ud_cnt_pkg::RADIX_DECADE
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         load,
    input  logic         ci_n,
    input  logic         up,
    input  logic [W-1:0] jam,
    output logic [W-1:0] count,
    output logic         co_n
);
    localparam logic [W-1:0] TOP = W'(ud_cnt_pkg::top_value(RADIX, W));

    logic [W-1:0] state_q;
    logic [W-1:0] step_nxt;

    ud_step #(.W(W), .RADIX(RADIX)) u_step (
        .cur (state_q),
        .up  (up),
        .nxt (step_nxt)
    );

    // Stored count: clear beats load beats counting; disabled edges hold.
    always_ff @(posedge clk) begin
        if (clr) begin
            state_q <= '0;
        end else if (load) begin
            state_q <= jam;
        end else if (!ci_n) begin
            state_q <= step_nxt;
        end
    end

    // Visible count: the level overrides appear without waiting for an edge.
    always_comb begin
        if (clr) begin
            count = '0;
        end else if (load) begin
            count = jam;
        end else begin
            count = state_q;
        end
    end

    ud_carry #(.W(W), .RADIX(RADIX)) u_carry (
        .cur  (count),
        .up   (up),
        .ci_n (ci_n),
        .co_n (co_n)
    );

    // R1: a clear seen at an edge leaves the stored count at zero.
    assert_clear_R1: assert property (@(posedge clk)
        clr |=> (state_q == '0));

    // R2: a load seen at an edge stores the jam value of that edge.
    assert_load_R2: assert property (@(posedge clk) disable iff (clr)
        load |=> (state_q == $past(jam)));

    // R6: a disabled digit keeps its stored value.
    assert_hold_R6: assert property (@(posedge clk) disable iff (clr)
        (!load && ci_n) |=> $stable(state_q));

    // R7: the carry out can only be active while the carry in is active.
    assert_carry_gate_R7: assert property (@(posedge clk) disable iff (clr)
        !co_n |-> !ci_n);

    // R8: one counting edge moves an out-of-range code back into range.
    assert_recover_R8: assert property (@(posedge clk) disable iff (clr)
        (!load && !ci_n && state_q > TOP) |=> (state_q <= TOP));

    // R8: no carry is issued while an out-of-range code is shown.
    assert_no_carry_illegal_R8: assert property (@(posedge clk) disable iff (clr)
        (count > TOP) |-> co_n);
endmodule

// File: tb/sim_ud_digit_counter.sv
module sim_ud_digit_counter;
    import ud_cnt_pkg::*;

    localparam int W = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic         clr = 1'b1, load = 1'b0, ci_n = 1'b0, up = 1'b1;
    logic [W-1:0] jam0 = '0;
    logic [W-1:0] q0, q1, q2, qb;
    logic         co0, co1, co2, cob;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    ud_digit_counter #(.W(W), .RADIX(RADIX_DECADE)) u0 (
        .clk(clk), .clr(clr), .load(load), .ci_n(ci_n), .up(up),
        .jam(jam0), .count(q0), .co_n(co0));
    ud_digit_counter #(.W(W), .RADIX(RADIX_DECADE)) u1 (
        .clk(clk), .clr(clr), .load(load), .ci_n(co0), .up(up),
        .jam(4'd0), .count(q1), .co_n(co1));
    ud_digit_counter #(.W(W), .RADIX(RADIX_DECADE)) u2 (
        .clk(clk), .clr(clr), .load(load), .ci_n(co1), .up(up),
        .jam(4'd0), .count(q2), .co_n(co2));
    ud_digit_counter #(.W(W), .RADIX(RADIX_BINARY)) u_bin (
        .clk(clk), .clr(clr), .load(load), .ci_n(ci_n), .up(up),
        .jam(jam0), .count(qb), .co_n(cob));

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // One counting edge, then sample at the following falling edge.
    task automatic edge1();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_clear();
        @(negedge clk);
        clr = 1; load = 1; jam0 = 4'd5; ci_n = 0;
        #1;
        chk("R3 clear beats load", q0, 0);
        edge1();
        chk("R1 clear after edge", q0, 0);
        load = 0;
        #1;
        chk("R1 clear alone", q0, 0);
        edge1();
        chk("R1 clear held", q0, 0);
    endtask

    task automatic t_load();
        clr = 0; load = 1; jam0 = 4'd7; ci_n = 0; up = 1;
        #1;
        chk("R2 load shows at once", q0, 7);
        edge1();
        edge1();
        chk("R2 load holds, no count", q0, 7);
        load = 0;
        edge1();
        chk("R4 count from loaded 7", q0, 8);
    endtask

    task automatic t_up_wrap();
        edge1();
        chk("R4 up to 9", q0, 9);
        chk("R7 carry at 9 up", co0, 0);
        ci_n = 1;
        #1;
        chk("R7 carry follows ci_n", co0, 1);
        edge1();
        chk("R6 hold with ci_n high", q0, 9);
        ci_n = 0;
        edge1();
        chk("R4 decade wrap 9->0", q0, 0);
        chk("R7 no carry at 0 up", co0, 1);
    endtask

    task automatic t_down_wrap();
        up = 0;
        #1;
        chk("R7 carry at 0 down", co0, 0);
        edge1();
        chk("R5 decade wrap 0->9", q0, 9);
        edge1();
        chk("R5 down to 8", q0, 8);
    endtask

    task automatic t_binary();
        load = 1; jam0 = 4'd14; up = 1;
        edge1();
        load = 0;
        edge1();
        chk("R4 binary up to 15", qb, 15);
        chk("R7 binary carry at 15", cob, 0);
        edge1();
        chk("R4 binary wrap 15->0", qb, 0);
        up = 0;
        edge1();
        chk("R5 binary wrap 0->15", qb, 15);
    endtask

    task automatic t_illegal();
        for (int c = 10; c <= 15; c++) begin
            for (int d = 0; d < 2; d++) begin
                up = (d == 0); ci_n = 0;
                load = 1; jam0 = W'(c);
                edge1();
                chk("R9 illegal code loads as-is", q0, c);
                chk("R8 no carry on illegal", co0, 1);
                load = 0;
                edge1();
                chk("R8 recovery in one edge", q0, (d == 0) ? 0 : 9);
            end
        end
    endtask

    task automatic t_cascade();
        clr = 1; load = 0; ci_n = 0; up = 1;
        edge1();
        clr = 0;
        for (int i = 1; i <= 1000; i++) begin
            edge1();
            chk("R10 chain up", q2 * 100 + q1 * 10 + q0, i % 1000);
        end
        up = 0;
        for (int i = 1; i <= 1000; i++) begin
            edge1();
            chk("R10 chain down", q2 * 100 + q1 * 10 + q0, (1000 - i) % 1000);
        end
    endtask

    initial begin
        t_clear();
        t_load();
        t_up_wrap();
        t_down_wrap();
        t_binary();
        t_illegal();
        t_cascade();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule